// File: doc/BRIEF.md
# I2C Clock-Low Watchdog and Interrupt Unit

This block sits beside an I2C target state machine. It counts, in system clock cycles, how long the synchronized SCL line has been held low. When the count exceeds a programmable 16-bit limit, it issues a one-cycle pulse that returns the state machine to idle. It also raises a sticky error flag that the next START condition clears.

The same unit turns protocol event strobes from the state machine into maskable single-cycle interrupt pulses. There are three of them: an address-acknowledge interrupt, a transfer-done interrupt (on STOP, or on a repeated START that reverses direction) and a timeout interrupt. A combined interrupt output is high whenever any of the three pulses is high.

Top module: `scl_watchdog_irq`

## Requirements
- R1: With `tmo_enable` high and `tmo_limit` = L (L >= 1), if `scl_sync` is sampled low on L+1 consecutive rising clock edges, `fsm_rst` is high for exactly the one cycle after the last of those edges. Counting then restarts from zero, so a low phase sampled on D edges gives floor(D/(L+1)) pulses.
- R2: Any rising edge that samples `scl_sync` high clears the low count without a pulse. A later low phase therefore counts again from zero.
- R3: With `tmo_enable` low, or with `tmo_limit` equal to zero, `fsm_rst`, `tmo_err` and `irq_tmo` never assert, whatever the length of the low phase.
- R4: `tmo_err` becomes 1 on the same edge that raises `fsm_rst`. It stays 1 until an edge samples `ev_start` high, and it is 0 after that edge. If a timeout and `ev_start` fall on the same edge, the timeout wins.
- R5: `irq_addr` is high for the one cycle after an edge that samples `ev_addr_ack` high while `en_addr_irq` is high. Otherwise it stays low.
- R6: `irq_xfer` is high for the one cycle after an edge that samples `ev_stop` or `ev_dir_change` high while `en_xfer_irq` is high. Otherwise it stays low.
- R7: `irq_tmo` is high in exactly the cycles where `fsm_rst` is high, provided `en_tmo_irq` was high on the edge that raised the pulse. Otherwise it stays low.
- R8: `irq_any` equals the OR of `irq_addr`, `irq_xfer` and `irq_tmo` in every cycle.
- R9: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_sync | input | 1 | SCL, already synchronized to clk |
| tmo_enable | input | 1 | Enables the clock-low watchdog |
| tmo_limit | input | 16 | Low-count limit; 0 disables the watchdog |
| en_addr_irq | input | 1 | Mask for the address-acknowledge interrupt |
| en_xfer_irq | input | 1 | Mask for the transfer-done interrupt |
| en_tmo_irq | input | 1 | Mask for the timeout interrupt |
| ev_start | input | 1 | START strobe; clears the error flag |
| ev_addr_ack | input | 1 | Address and R/W acknowledged strobe |
| ev_stop | input | 1 | STOP condition strobe |
| ev_dir_change | input | 1 | Repeated START with reversed direction strobe |
| fsm_rst | output | 1 | One-cycle reset pulse to the target state machine |
| tmo_err | output | 1 | Sticky timeout error flag |
| irq_addr | output | 1 | Address-acknowledge interrupt pulse |
| irq_xfer | output | 1 | Transfer-done interrupt pulse |
| irq_tmo | output | 1 | Timeout interrupt pulse |
| irq_any | output | 1 | Combined interrupt |

## Verification
Every result sits exactly one register stage behind the edge that samples its cause. An event strobe shows up on its interrupt one cycle later. A timeout pulse follows the (L+1)-th low-sampled edge. The error flag changes on the same edge as the pulse, or on the edge that samples `ev_start`. The bench drives inputs on falling edges and reads outputs on the following falling edge, so every sample falls half a period after the register that produced it. For the low-phase sweep, each expected pulse count and error state is computed as floor(D/(L+1)) in the bench.

// File: rtl/scl_wd_pkg.sv
package scl_wd_pkg;
  localparam int unsigned NUM_IRQ = 3;
  typedef enum logic [1:0] {
    IRQ_ADDR = 2'd0,
    IRQ_XFER = 2'd1,
    IRQ_TMO  = 2'd2
  } irq_idx_e;
endpackage

// File: rtl/scl_low_timer.sv
module scl_low_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_low,
  input  logic          enable,
  input  logic [TW-1:0] limit,
  output logic          hit,
  output logic          expire
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          armed;
  logic          expire_q;

  always_comb begin
    armed = enable && (limit != '0);
    hit   = armed && scl_low && (cnt_q == limit);
    if (!armed || !scl_low || hit) cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      expire_q <= hit;
    end
  end

  assign expire = expire_q;

  AST_HIGH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_low |=> (cnt_q == '0)); // R2
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || limit == '0) |=> !expire_q); // R3
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |-> (cnt_q == '0)); // R1
endmodule

// File: rtl/irq_pulser.sv
module irq_pulser #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] en,
  output logic [N-1:0] irq
);
  logic [N-1:0] irq_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic fire_d;
    always_comb fire_d = ev[i] && en[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[i] <= 1'b0;
      else        irq_q[i] <= fire_d;
    end
    AST_MASKED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |=> !irq_q[i]); // R5
  end

  assign irq = irq_q;
endmodule

// File: rtl/scl_watchdog_irq.sv
module scl_watchdog_irq
  import scl_wd_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_sync,
  input  logic          tmo_enable,
  input  logic [TW-1:0] tmo_limit,
  input  logic          en_addr_irq,
  input  logic          en_xfer_irq,
  input  logic          en_tmo_irq,
  input  logic          ev_start,
  input  logic          ev_addr_ack,
  input  logic          ev_stop,
  input  logic          ev_dir_change,
  output logic          fsm_rst,
  output logic          tmo_err,
  output logic          irq_addr,
  output logic          irq_xfer,
  output logic          irq_tmo,
  output logic          irq_any
);
  logic               tmo_hit;
  logic               err_q, err_d;
  logic [NUM_IRQ-1:0] ev_vec, en_vec, irq_vec;

  scl_low_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_low (!scl_sync),
    .enable  (tmo_enable),
    .limit   (tmo_limit),
    .hit     (tmo_hit),
    .expire  (fsm_rst)
  );

  always_comb begin
    ev_vec           = '0;
    en_vec           = '0;
    ev_vec[IRQ_ADDR] = ev_addr_ack;
    ev_vec[IRQ_XFER] = ev_stop || ev_dir_change;
    ev_vec[IRQ_TMO]  = tmo_hit;
    en_vec[IRQ_ADDR] = en_addr_irq;
    en_vec[IRQ_XFER] = en_xfer_irq;
    en_vec[IRQ_TMO]  = en_tmo_irq;
  end

  irq_pulser #(.N(NUM_IRQ)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (ev_vec),
    .en    (en_vec),
    .irq   (irq_vec)
  );

  always_comb begin
    if (tmo_hit)       err_d = 1'b1;
    else if (ev_start) err_d = 1'b0;
    else               err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign tmo_err  = err_q;
  assign irq_addr = irq_vec[IRQ_ADDR];
  assign irq_xfer = irq_vec[IRQ_XFER];
  assign irq_tmo  = irq_vec[IRQ_TMO];
  assign irq_any  = |irq_vec;

  AST_ERR_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_rst |-> tmo_err); // R4
  AST_TMO_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tmo |-> fsm_rst); // R7
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_err && !ev_start) |=> tmo_err); // R4
  AST_XFER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_xfer_irq |=> !irq_xfer); // R6
endmodule

// File: tb/tb_scl_watchdog_irq.sv
`timescale 1ns/1ps
module tb_scl_watchdog_irq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl_sync, tmo_enable;
  logic [15:0] tmo_limit;
  logic        en_addr_irq, en_xfer_irq, en_tmo_irq;
  logic        ev_start, ev_addr_ack, ev_stop, ev_dir_change;
  logic        fsm_rst, tmo_err, irq_addr, irq_xfer, irq_tmo, irq_any;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  scl_watchdog_irq dut (
    .clk(clk), .rst_n(rst_n), .scl_sync(scl_sync), .tmo_enable(tmo_enable),
    .tmo_limit(tmo_limit), .en_addr_irq(en_addr_irq), .en_xfer_irq(en_xfer_irq),
    .en_tmo_irq(en_tmo_irq), .ev_start(ev_start), .ev_addr_ack(ev_addr_ack),
    .ev_stop(ev_stop), .ev_dir_change(ev_dir_change), .fsm_rst(fsm_rst),
    .tmo_err(tmo_err), .irq_addr(irq_addr), .irq_xfer(irq_xfer),
    .irq_tmo(irq_tmo), .irq_any(irq_any)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_err();
    @(negedge clk) ev_start = 1'b1; scl_sync = 1'b1;
    @(negedge clk) ev_start = 1'b0;
  endtask

  // low phase of d edges; returns number of fsm_rst pulses, checks R7/R8 each cycle
  task automatic low_phase(input int d, input bit tmo_irq_en, output int pulses);
    pulses = 0;
    for (int i = 0; i < d; i++) begin
      scl_sync = 1'b0;
      @(negedge clk);
      if (fsm_rst) pulses++;
      if (irq_tmo != (fsm_rst && tmo_irq_en)) chk("R7", irq_tmo, fsm_rst && tmo_irq_en);
      if (irq_any != (irq_addr | irq_xfer | irq_tmo)) chk("R8", irq_any, 0);
    end
    scl_sync = 1'b1;
    @(negedge clk);
    if (fsm_rst) pulses++;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; scl_sync = 1'b1; tmo_enable = 1'b0; tmo_limit = '0;
    en_addr_irq = 1'b0; en_xfer_irq = 1'b0; en_tmo_irq = 1'b0;
    ev_start = 1'b0; ev_addr_ack = 1'b0; ev_stop = 1'b0; ev_dir_change = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 outputs in reset", {fsm_rst, tmo_err, irq_addr, irq_xfer, irq_tmo, irq_any}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R7: sweep of limit, low length, enable
    for (int en = 0; en < 2; en++) begin
      for (int lim = 0; lim < 6; lim++) begin
        for (int d = 0; d < 13; d++) begin
          int p, exp_p;
          bit ti;
          clear_err();
          ti = ((d + lim) % 2) == 1;
          tmo_enable = en[0]; tmo_limit = 16'(lim); en_tmo_irq = ti;
          low_phase(d, ti, p);
          exp_p = (en == 1 && lim > 0) ? d / (lim + 1) : 0;
          if (en == 1 && lim > 0) chk("R1 pulse count", p, exp_p);
          else                    chk("R3 disabled no pulse", p, 0);
          chk("R4 error after phase", tmo_err, exp_p > 0);
        end
      end
    end

    // R2: interrupted low phases never accumulate
    clear_err();
    tmo_enable = 1'b1; tmo_limit = 16'd4;
    for (int k = 0; k < 5; k++) begin
      int p;
      low_phase(4, 1'b0, p);
      chk("R2 high clears count", p, 0);
    end
    chk("R2 no error", tmo_err, 0);

    // R4: error sticky through high SCL, cleared by start
    tmo_limit = 16'd1;
    begin
      int p;
      low_phase(2, 1'b1, p);
      chk("R1 limit 1 pulse", p, 1);
    end
    repeat (5) @(negedge clk);
    chk("R4 error held", tmo_err, 1);
    ev_start = 1'b1;
    @(negedge clk) ev_start = 1'b0;
    chk("R4 error cleared by start", tmo_err, 0);

    // R4: timeout and start on the same edge -> error set
    tmo_limit = 16'd2;
    scl_sync = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ev_start = 1'b1;
    @(negedge clk);
    ev_start = 1'b0; scl_sync = 1'b1;
    chk("R4 pulse at third edge", fsm_rst, 1);
    chk("R4 timeout beats start", tmo_err, 1);
    clear_err();
    tmo_enable = 1'b0;

    // R5 R6 R8: every enable mask against every event pattern
    for (int m = 0; m < 8; m++) begin
      for (int e = 1; e < 8; e++) begin
        bit xa, xx;
        en_addr_irq = m[0]; en_xfer_irq = m[1]; en_tmo_irq = m[2];
        ev_addr_ack = e[0]; ev_stop = e[1]; ev_dir_change = e[2];
        @(negedge clk);
        ev_addr_ack = 1'b0; ev_stop = 1'b0; ev_dir_change = 1'b0;
        xa = e[0] && m[0];
        xx = (e[1] || e[2]) && m[1];
        chk("R5 addr irq", irq_addr, xa);
        chk("R6 xfer irq", irq_xfer, xx);
        chk("R8 combined irq", irq_any, xa || xx);
        @(negedge clk);
        chk("R5 R6 single cycle", {irq_addr, irq_xfer, irq_any}, 0);
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule